// File: doc/BRIEF.md
# Asynchronous DRAM Strobe Sequencer

This block sits between a simple host port and an asynchronous DRAM of 256K locations by 8 bits. The host presents a read or write together with an 18-bit address. The block splits the address into a 9-bit row and a 9-bit column and sends both over one shared 9-bit address bus, row first. It then produces the active-low row strobe, column strobe, write enable and output enable in the order that each kind of access requires. Every phase is held for a parameterised number of clock cycles. This keeps the row-to-column delay, the minimum row-low time and the precharge time at or above their minimums.

An internal interval counter raises a refresh request at a fixed period. The block then runs a row-only refresh cycle on the row held in its own wrapping counter. The refresh runs ahead of any host request that is waiting at the same moment. The host holds its request until it sees a one-cycle acknowledge. The acknowledge comes when read data is valid on the read-data port, or when a write has finished.

Top module: `dram_strobe_seq`

## Requirements
- R1: The address bus carries the row (request address bits 17..9) when the row strobe falls, and the column (bits 8..0) when the column strobe falls.
- R2: During and right after reset, all four strobes are high (inactive), the acknowledge is low and the data-drive enable is low.
- R3: A read runs row strobe fall, then column strobe fall with output enable low, then row strobe rise while the column strobe is still low, then column strobe rise.
- R4: A write runs row strobe fall, then write-enable fall with write data driven, then column strobe fall, then write-enable rise, then row strobe rise, then column strobe rise. The data-drive enable is high and the data equals the host write data whenever write enable falls.
- R5: A refresh toggles only the row strobe. The column strobe, write enable and output enable stay high for the whole refresh.
- R6: The column strobe falls no sooner than T_RCD cycles after the row strobe falls.
- R7: The row strobe stays low for at least T_RAS cycles.
- R8: The row strobe stays high for at least T_RP cycles before its next fall.
- R9: Read data is sampled no sooner than T_RCD + T_CAC cycles after the row strobe falls, and it is presented on the read-data port together with the acknowledge.
- R10: Each host request gets exactly one acknowledge, and that acknowledge is high for a single cycle.
- R11: A refresh becomes pending every REF_PERIOD cycles. Refresh rows start at 0, go up by one per refresh, and wrap from 511 back to 0.
- R12: When a refresh is pending and a host request is also waiting, the refresh starts first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Host request, held until acknowledged |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 18 | Host address, row in the upper 9 bits |
| req_wdata | input | 8 | Host write data |
| req_ack | output | 1 | One-cycle acknowledge |
| req_rdata | output | 8 | Read data, valid with the acknowledge |
| dram_addr | output | 9 | Shared row/column address bus |
| dram_ras_n | output | 1 | Row strobe, active low |
| dram_cas_n | output | 1 | Column strobe, active low |
| dram_we_n | output | 1 | Write enable, active low |
| dram_oe_n | output | 1 | Output enable, active low |
| dram_dq_out | output | 8 | Data toward the memory |
| dram_dq_oe | output | 1 | High while the block drives the data bus |
| dram_dq_in | input | 8 | Data from the memory |

## Verification
The bench builds the block with T_RCD=2, T_CAC=2, T_RAS=5, T_RP=2 and REF_PERIOD=40. Because T_RAS exceeds T_RCD + T_CAC, the column phase has to stretch to satisfy the row-low minimum. A memory model that returns junk until T_CAC cycles after the column strobe falls exposes any early sampling. The short refresh period yields more than 512 refreshes during a sweep of every row and every column. That is enough to reach the row-counter wrap and to produce many collisions between pending refreshes and waiting host requests.

// File: rtl/dseq_pkg.sv
package dseq_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_ROW,
        S_WEN,
        S_COL,
        S_WREL,
        S_RREL,
        S_REF,
        S_PRE
    } seq_state_e;

    typedef struct packed {
        logic ras_n;
        logic cas_n;
        logic we_n;
        logic oe_n;
    } strobe_t;

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    // Strobe levels held during each phase of the sequencer.
    function automatic strobe_t strobes_of(input seq_state_e s, input logic wr);
        strobe_t t;
        t = '1;
        case (s)
            S_ROW, S_REF: t.ras_n = 1'b0;
            S_WEN: begin
                t.ras_n = 1'b0;
                t.we_n  = 1'b0;
            end
            S_COL: begin
                t.ras_n = 1'b0;
                t.cas_n = 1'b0;
                t.we_n  = ~wr;
                t.oe_n  = wr;
            end
            S_WREL: begin
                t.ras_n = 1'b0;
                t.cas_n = 1'b0;
            end
            S_RREL: begin
                t.cas_n = 1'b0;
                t.oe_n  = wr;
            end
            default: t = '1;
        endcase
        return t;
    endfunction

endpackage

// File: rtl/dseq_phase_timer.sv
module dseq_phase_timer #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expired
);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load) begin
            cnt_d = load_val;
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign expired = (cnt_q == '0);

    AST_TIMER_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
        (load && load_val != '0) |=> !expired); // R6

endmodule

// File: rtl/dseq_refresh_sched.sv
module dseq_refresh_sched #(
    parameter int ROW_W      = 9,
    parameter int REF_PERIOD = 1560
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             serve,
    output logic             pending,
    output logic [ROW_W-1:0] ref_row
);

    localparam int PER_W = $clog2(REF_PERIOD + 1);

    typedef struct packed {
        logic [PER_W-1:0] tick;
        logic             pend;
        logic [ROW_W-1:0] row;
    } sched_t;

    sched_t q, d;

    always_comb begin
        d = q;
        if (serve) begin
            d.pend = 1'b0;
            d.row  = q.row + 1'b1;
        end
        if (q.tick == PER_W'(REF_PERIOD - 1)) begin
            d.tick = '0;
            d.pend = 1'b1;
        end else begin
            d.tick = q.tick + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign pending = q.pend;
    assign ref_row = q.row;

    AST_SERVE_WHEN_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
        serve |-> pending); // R12
    AST_ROW_WRAPS: assert property (@(posedge clk) disable iff (!rst_n)
        (serve && ref_row == '1) |=> ref_row == '0); // R11

endmodule

// File: rtl/dram_strobe_seq.sv
module dram_strobe_seq
    import dseq_pkg::*;
#(
    parameter int ROW_W      = 9,
    parameter int COL_W      = 9,
    parameter int DATA_W     = 8,
    parameter int T_RCD      = 2,
    parameter int T_CAC      = 2,
    parameter int T_RAS      = 5,
    parameter int T_RP       = 3,
    parameter int REF_PERIOD = 1560
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     req_valid,
    input  logic                     req_write,
    input  logic [ROW_W+COL_W-1:0]   req_addr,
    input  logic [DATA_W-1:0]        req_wdata,
    output logic                     req_ack,
    output logic [DATA_W-1:0]        req_rdata,
    output logic [imax(ROW_W,COL_W)-1:0] dram_addr,
    output logic                     dram_ras_n,
    output logic                     dram_cas_n,
    output logic                     dram_we_n,
    output logic                     dram_oe_n,
    output logic [DATA_W-1:0]        dram_dq_out,
    output logic                     dram_dq_oe,
    input  logic [DATA_W-1:0]        dram_dq_in
);

    localparam int ADDR_W     = ROW_W + COL_W;
    localparam int MUX_W      = imax(ROW_W, COL_W);
    // Column phase length stretched so the row-low minimum is met.
    localparam int RD_COL_LEN = imax(T_CAC, T_RAS - T_RCD);
    localparam int WR_COL_LEN = imax(T_CAC, T_RAS - T_RCD - 2);
    localparam int MAX_LEN    = imax(imax(imax(T_RCD, T_RAS), imax(T_RP, 1)),
                                     imax(RD_COL_LEN, WR_COL_LEN));
    localparam int CNT_W      = $clog2(MAX_LEN + 1);
    localparam int AGE_W      = $clog2(MAX_LEN + T_RCD + 8);

    localparam logic [CNT_W-1:0] L_RCD = CNT_W'(T_RCD - 1);
    localparam logic [CNT_W-1:0] L_RAS = CNT_W'(T_RAS - 1);
    localparam logic [CNT_W-1:0] L_RP  = CNT_W'(T_RP - 1);
    localparam logic [CNT_W-1:0] L_RDC = CNT_W'(RD_COL_LEN - 1);
    localparam logic [CNT_W-1:0] L_WRC = CNT_W'(WR_COL_LEN - 1);

    typedef struct packed {
        seq_state_e        st;
        logic              wr;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
        strobe_t           stb;
        logic [MUX_W-1:0]  mux;
        logic              dq_oe;
        logic              ack;
        logic [DATA_W-1:0] rdata;
    } ctl_t;

    ctl_t q, d;

    logic             tmr_load;
    logic [CNT_W-1:0] tmr_len;
    logic             tmr_expired;
    logic             ref_pending;
    logic             ref_serve;
    logic [ROW_W-1:0] ref_row;

    dseq_phase_timer #(.CNT_W(CNT_W)) i_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_len),
        .expired  (tmr_expired)
    );

    dseq_refresh_sched #(.ROW_W(ROW_W), .REF_PERIOD(REF_PERIOD)) i_refresh (
        .clk     (clk),
        .rst_n   (rst_n),
        .serve   (ref_serve),
        .pending (ref_pending),
        .ref_row (ref_row)
    );

    always_comb begin
        d         = q;
        d.ack     = 1'b0;
        tmr_load  = 1'b0;
        tmr_len   = '0;
        ref_serve = 1'b0;

        case (q.st)
            S_IDLE: begin
                if (ref_pending) begin
                    d.st      = S_REF;
                    tmr_load  = 1'b1;
                    tmr_len   = L_RAS;
                    ref_serve = 1'b1;
                end else if (req_valid) begin
                    d.st     = S_ROW;
                    d.wr     = req_write;
                    d.addr   = req_addr;
                    d.wdata  = req_wdata;
                    tmr_load = 1'b1;
                    tmr_len  = L_RCD;
                end
            end
            S_ROW: begin
                if (tmr_expired) begin
                    tmr_load = 1'b1;
                    if (q.wr) begin
                        d.st    = S_WEN;
                        tmr_len = '0;
                    end else begin
                        d.st    = S_COL;
                        tmr_len = L_RDC;
                    end
                end
            end
            S_WEN: begin
                if (tmr_expired) begin
                    d.st     = S_COL;
                    tmr_load = 1'b1;
                    tmr_len  = L_WRC;
                end
            end
            S_COL: begin
                if (tmr_expired) begin
                    tmr_load = 1'b1;
                    if (q.wr) begin
                        d.st = S_WREL;
                    end else begin
                        d.st    = S_RREL;
                        d.ack   = 1'b1;
                        d.rdata = dram_dq_in;
                    end
                end
            end
            S_WREL: begin
                if (tmr_expired) begin
                    d.st     = S_RREL;
                    tmr_load = 1'b1;
                end
            end
            S_RREL: begin
                if (tmr_expired) begin
                    d.st     = S_PRE;
                    d.ack    = q.wr;
                    tmr_load = 1'b1;
                    tmr_len  = L_RP;
                end
            end
            S_REF: begin
                if (tmr_expired) begin
                    d.st     = S_PRE;
                    tmr_load = 1'b1;
                    tmr_len  = L_RP;
                end
            end
            S_PRE: begin
                if (tmr_expired) begin
                    d.st = S_IDLE;
                end
            end
            default: d.st = S_IDLE;
        endcase

        d.stb = strobes_of(d.st, d.wr);
        case (d.st)
            S_ROW, S_WEN:          d.mux = MUX_W'(d.addr[ADDR_W-1:COL_W]);
            S_COL, S_WREL, S_RREL: d.mux = MUX_W'(d.addr[COL_W-1:0]);
            S_REF:                 d.mux = MUX_W'(ref_row);
            default:               d.mux = '0;
        endcase
        d.dq_oe = d.wr && (d.st == S_WEN || d.st == S_COL || d.st == S_WREL);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q     <= '0;
            q.stb <= '1;
        end else begin
            q <= d;
        end
    end

    assign req_ack     = q.ack;
    assign req_rdata   = q.rdata;
    assign dram_addr   = q.mux;
    assign dram_ras_n  = q.stb.ras_n;
    assign dram_cas_n  = q.stb.cas_n;
    assign dram_we_n   = q.stb.we_n;
    assign dram_oe_n   = q.stb.oe_n;
    assign dram_dq_out = q.wdata;
    assign dram_dq_oe  = q.dq_oe;

    // Cycle counters on the row strobe, kept only for the timing checks below.
    logic [AGE_W-1:0] ras_lo_cnt, ras_hi_cnt;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ras_lo_cnt <= '0;
            ras_hi_cnt <= '1;
        end else begin
            ras_lo_cnt <= dram_ras_n ? '0 : ((ras_lo_cnt == '1) ? ras_lo_cnt : ras_lo_cnt + 1'b1);
            ras_hi_cnt <= !dram_ras_n ? '0 : ((ras_hi_cnt == '1) ? ras_hi_cnt : ras_hi_cnt + 1'b1);
        end
    end

    AST_CAS_UNDER_RAS: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(dram_cas_n) |-> !dram_ras_n); // R3
    AST_RAS_RELEASED_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dram_cas_n) |-> dram_ras_n); // R3
    AST_WE_INSIDE_ROW: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(dram_we_n) |-> (!dram_ras_n && dram_cas_n && dram_dq_oe)); // R4
    AST_RCD_MIN: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(dram_cas_n) |-> ras_lo_cnt >= AGE_W'(T_RCD)); // R6
    AST_RAS_LOW_MIN: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dram_ras_n) |-> ras_lo_cnt >= AGE_W'(T_RAS)); // R7
    AST_PRECHARGE_MIN: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(dram_ras_n) |-> ras_hi_cnt >= AGE_W'(T_RP)); // R8
    AST_ACK_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        req_ack |=> !req_ack); // R10

endmodule

// File: tb/test_dram_strobe_seq.sv
module test_dram_strobe_seq;

    localparam int CLK_PERIOD = 10;
    localparam int T_RCD      = 2;
    localparam int T_CAC      = 2;
    localparam int T_RAS      = 5;
    localparam int T_RP       = 2;
    localparam int REF_PERIOD = 40;
    localparam int NROWS      = 512;
    localparam int WATCHDOG   = 150000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [17:0] req_addr = '0;
    logic [7:0]  req_wdata = '0;
    logic        req_ack;
    logic [7:0]  req_rdata;
    logic [8:0]  dram_addr;
    logic        dram_ras_n, dram_cas_n, dram_we_n, dram_oe_n;
    logic [7:0]  dram_dq_out;
    logic        dram_dq_oe;
    logic [7:0]  dram_dq_in = 8'hC3;

    dram_strobe_seq #(
        .ROW_W(9), .COL_W(9), .DATA_W(8),
        .T_RCD(T_RCD), .T_CAC(T_CAC), .T_RAS(T_RAS), .T_RP(T_RP),
        .REF_PERIOD(REF_PERIOD)
    ) i_dram_strobe_seq (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata),
        .req_ack(req_ack), .req_rdata(req_rdata),
        .dram_addr(dram_addr), .dram_ras_n(dram_ras_n), .dram_cas_n(dram_cas_n),
        .dram_we_n(dram_we_n), .dram_oe_n(dram_oe_n),
        .dram_dq_out(dram_dq_out), .dram_dq_oe(dram_dq_oe), .dram_dq_in(dram_dq_in)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int n_checks = 0;
    int n_fail   = 0;
    int cyc      = 0;

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    always @(posedge clk) begin
        if (rst_n) cyc++;
        if (cyc > WATCHDOG) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual %0d cycles expected at most %0d", cyc, WATCHDOG);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
            $finish;
        end
    end

    // Host-side expectations and memory model state.
    logic [7:0]  golden [int];
    logic [7:0]  cells  [int];
    logic [17:0] cur_addr  = '0;
    logic [7:0]  cur_wdata = '0;
    int ops_done = 0;
    int ack_seen = 0;
    int ref_cnt  = 0;
    int prio_hits = 0;

    logic p_ras = 1'b1, p_cas = 1'b1, p_we = 1'b1, p_ack = 1'b0;
    int   ras_fall_c = 0;
    int   ras_rise_c = -1000;
    int   cas_age = 0;
    logic [8:0] row_lat = '0, col_lat = '0;
    bit saw_cas = 0, saw_we = 0, pend_old = 0, ref_quiet = 1;

    // Strobe monitor and behavioural memory, evaluated away from the active edge.
    always @(negedge clk) begin
        if (!rst_n) begin
            p_ras = 1'b1; p_cas = 1'b1; p_we = 1'b1; p_ack = 1'b0; cas_age = 0;
        end else begin
            if (p_ras && !dram_ras_n) begin
                check(cyc - ras_rise_c >= T_RP, "R8 precharge cycles", cyc - ras_rise_c, T_RP);
                check(dram_cas_n && dram_we_n, "R3 CAS/WE high at RAS fall",
                      {dram_cas_n, dram_we_n}, 3);
                row_lat = dram_addr; saw_cas = 0; saw_we = 0; ref_quiet = 1;
                ras_fall_c = cyc;
                pend_old = (cyc >= 3) && (((cyc - 3) / REF_PERIOD) > ref_cnt);
            end
            if (!dram_ras_n && (!dram_oe_n || !dram_we_n)) ref_quiet = 0;
            if (p_we && !dram_we_n) begin
                check(!dram_ras_n && dram_cas_n, "R4 WE falls between RAS and CAS",
                      {dram_ras_n, dram_cas_n}, 1);
                check(dram_dq_oe && dram_dq_out == cur_wdata, "R4 write data driven",
                      dram_dq_out, cur_wdata);
                saw_we = 1;
            end
            if (p_cas && !dram_cas_n) begin
                check(!dram_ras_n, "R3 CAS falls under RAS", dram_ras_n, 0);
                check(cyc - ras_fall_c >= T_RCD, "R6 RAS-to-CAS cycles", cyc - ras_fall_c, T_RCD);
                check({row_lat, dram_addr} == cur_addr, "R1 row/column on address bus",
                      {row_lat, dram_addr}, cur_addr);
                col_lat = dram_addr;
                saw_cas = 1;
                if (saw_we) begin
                    check(!dram_we_n, "R4 WE low at CAS fall", dram_we_n, 0);
                    cells[int'({row_lat, dram_addr})] = dram_dq_out;
                end else begin
                    check(!dram_oe_n, "R3 OE low for read", dram_oe_n, 0);
                end
            end
            if (!p_we && dram_we_n) begin
                check(!dram_ras_n && !dram_cas_n, "R4 WE released before RAS and CAS",
                      {dram_ras_n, dram_cas_n}, 0);
            end
            if (!p_ras && dram_ras_n) begin
                check(cyc - ras_fall_c >= T_RAS, "R7 RAS low cycles", cyc - ras_fall_c, T_RAS);
                if (saw_cas) begin
                    check(!dram_cas_n, saw_we ? "R4 RAS released before CAS" : "R3 RAS released before CAS",
                          dram_cas_n, 0);
                    check(dram_we_n, "R4 WE high at RAS rise", dram_we_n, 1);
                    if (pend_old) check(0, "R12 refresh pending but host access started", 1, 0);
                end else begin
                    check(row_lat == 9'(ref_cnt % NROWS), "R11 refresh row sequence",
                          row_lat, ref_cnt % NROWS);
                    check(ref_quiet && dram_cas_n && dram_we_n && dram_oe_n, "R5 refresh is RAS only",
                          ref_quiet, 1);
                    if (pend_old) begin
                        prio_hits++;
                        check(1, "R12 pending refresh served first", 1, 1);
                    end
                    ref_cnt++;
                end
                ras_rise_c = cyc;
            end
            if (!p_cas && dram_cas_n) begin
                check(dram_ras_n, "R3 CAS released after RAS", dram_ras_n, 1);
            end
            if (req_ack) begin
                check(!p_ack, "R10 acknowledge lasts one cycle", p_ack, 0);
                ack_seen++;
            end
            if (!dram_cas_n) cas_age++; else cas_age = 0;
            if (!dram_cas_n && !dram_oe_n && cas_age >= T_CAC && cells.exists(int'({row_lat, col_lat})))
                dram_dq_in = cells[int'({row_lat, col_lat})];
            else
                dram_dq_in = 8'hC3;
            p_ras = dram_ras_n; p_cas = dram_cas_n; p_we = dram_we_n; p_ack = req_ack;
        end
    end

    function automatic logic [7:0] data_of(input logic [17:0] a);
        return a[7:0] ^ a[16:9] ^ 8'h3C;
    endfunction

    task automatic host_op(input bit wr, input logic [17:0] a, input logic [7:0] dat);
        @(negedge clk);
        cur_addr  = a;
        cur_wdata = dat;
        req_valid = 1'b1;
        req_write = wr;
        req_addr  = a;
        req_wdata = dat;
        do @(negedge clk); while (!req_ack);
        req_valid = 1'b0;
        ops_done++;
        if (wr) begin
            golden[int'(a)] = dat;
        end else begin
            check(golden.exists(int'(a)) && req_rdata == golden[int'(a)], "R9 read data",
                  req_rdata, golden[int'(a)]);
            check(cyc - ras_fall_c >= T_RCD + T_CAC, "R9 read latency cycles",
                  cyc - ras_fall_c, T_RCD + T_CAC);
        end
    endtask

    initial begin
        repeat (4) @(negedge clk);
        // R2: reset state
        check(dram_ras_n && dram_cas_n && dram_we_n && dram_oe_n, "R2 strobes high in reset",
              {dram_ras_n, dram_cas_n, dram_we_n, dram_oe_n}, 15);
        check(!req_ack && !dram_dq_oe, "R2 ack and drive low in reset", {req_ack, dram_dq_oe}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(dram_ras_n && dram_cas_n && dram_we_n && dram_oe_n, "R2 strobes high after reset",
              {dram_ras_n, dram_cas_n, dram_we_n, dram_oe_n}, 15);

        for (int r = 0; r < NROWS; r++) begin
            logic [17:0] a;
            a = {9'(r), 9'((r * 37) % NROWS)};
            host_op(1'b1, a, data_of(a));
        end
        for (int c = 0; c < NROWS; c++) begin
            logic [17:0] a;
            a = {9'h155, 9'(c)};
            host_op(1'b1, a, data_of(a) ^ 8'hFF);
        end
        for (int r = 0; r < NROWS; r++) begin
            host_op(1'b0, {9'(r), 9'((r * 37) % NROWS)}, 8'h00);
        end
        for (int c = 0; c < NROWS; c++) begin
            host_op(1'b0, {9'h155, 9'(c)}, 8'h00);
        end

        while (ref_cnt < NROWS + 4) @(negedge clk);
        repeat (8) @(negedge clk);

        check(ack_seen == ops_done, "R10 one acknowledge per request", ack_seen, ops_done);
        check(ref_cnt >= (cyc / REF_PERIOD) - 1, "R11 refresh rate", ref_cnt, (cyc / REF_PERIOD) - 1);
        check(prio_hits > 0, "R12 refresh/request collisions exercised", prio_hits, 1);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

endmodule